// File: doc/BRIEF.md
# SMBus Backlight Control Register Slave

This block is the serial control front end of an LED backlight driver. It watches a two-wire SMBus (clock and open-drain data, both oversampled by the local clock), recognises START, repeated START and STOP, and answers the write-byte and read-byte protocols at the fixed 7-bit address 0x2C (address byte 0x58 to write, 0x59 to read). It pulls SDA low only through an output-enable pin; the pad and pull-up are outside.

Behind the bus sit four 8-bit registers: a brightness level, a control byte (backlight on, brightness source, PWM interpretation), a live read-only fault/status byte built from flags supplied by the rest of the driver, and a read-only identity byte. From these and an external PWM duty code the block forms the effective brightness that the dimming logic consumes: the register value, the PWM duty itself, or the register value scaled by the duty fraction.

Top module: `smb_backlight_regs`

## Requirements
- R1: An address byte whose upper seven bits differ from 0x2C is not acknowledged (SDA stays released) and the rest of that transfer changes no register.
- R2: Write-byte (START, 0x58, command, data, STOP) acknowledges all three bytes and stores the data in the register the command selects.
- R3: Read-byte (START, 0x58, command, repeated START, 0x59, then one data byte MSB first) acknowledges the three master bytes, drives the selected register onto SDA, and releases SDA for the master's NACK.
- R4: Command 0x00 is the brightness register: read/write, reset value 0xFF, and a read returns the stored value in every mode.
- R5: Command 0x01 is the control register, reset 0x00: bit 0 drives bl_en_o, bit 1 drives pwm_sel_o, bit 2 drives pwm_abs_o; bits 7:3 read 0 and ignore writes. A write reaches these outputs 4 clocks after the SCL falling edge that opens the data ACK; clearing bit 0 turns the backlight off at once.
- R6: Command 0x02 is read-only and sampled when the read data byte is loaded: bit 0 = any fault (thermal, overcurrent or any string), bit 1 = thermal, bit 2 = overcurrent, bit 3 = backlight status input, bits 5:4 = faulted-string count coded 00 none, 01 one, 11 two or more, bits 7:6 = 0.
- R7: Command 0x03 is read-only and reads {1, 4-bit maker code 6, 3-bit revision}, 0xB0 with the default revision 0.
- R8: Commands 0x04 and above are acknowledged, writes to them change nothing, and reads return 0x00.
- R9: With control bit 1 = 0 and bit 2 = 1, brightness_o equals the brightness register.
- R10: With control bit 1 = 1, brightness_o equals the PWM duty code; brightness register writes then do not move brightness_o.
- R11: With control bits 2:1 = 00, brightness_o = (brightness × duty + 255) >> 8, so 0xFF × 0xFF gives 0xFF and a zero on either side gives 0.
- R12: brightness_o follows the selected source one clock after it changes, and SDA is released after every STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, oversamples the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SMBus clock level |
| sda_i | input | 1 | SMBus data level (wired line) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| pwm_duty_i | input | 8 | PWM duty code, 0x00..0xFF |
| tsd_fault_i | input | 1 | Thermal shutdown flag |
| ocp_fault_i | input | 1 | Input overcurrent flag |
| string_fault_i | input | NUM_STRINGS | Per-string open/short fault flags |
| bl_status_i | input | 1 | Backlight running status |
| brightness_o | output | 8 | Effective brightness |
| bl_en_o | output | 1 | Backlight enable |
| pwm_sel_o | output | 1 | Brightness taken from the PWM duty |
| pwm_abs_o | output | 1 | PWM duty read as absolute, not percent |

## Verification
Each result has a fixed due cycle: brightness_o follows a duty or mode change one clock later, control outputs move 4 clocks after the SCL fall that opens the data ACK and brightness_o 5 clocks after it, while acknowledge and read bits are valid on SDA at every SCL high. A behavioural model in the bench holds the expected register contents and recomputes the effective brightness from the duty seen at the previous clock edge, and it is compared with the outputs on every clock outside bus transfers. Bus-visible results (acknowledge bits, read bytes, SDA release after STOP) are sampled in the middle of the SCL high phase, well past the three-clock synchroniser delay.

// File: rtl/smb_bl_pkg.sv
package smb_bl_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_CMD,
    ST_CMD_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_SKIP
  } link_state_e;

  localparam int unsigned BYTE_W = 8;

  localparam logic [7:0] CMD_BRT = 8'h00;
  localparam logic [7:0] CMD_CTL = 8'h01;
  localparam logic [7:0] CMD_STS = 8'h02;
  localparam logic [7:0] CMD_ID  = 8'h03;

  localparam int unsigned CTL_BL  = 0;
  localparam int unsigned CTL_SEL = 1;
  localparam int unsigned CTL_ABS = 2;

endpackage

// File: rtl/smb_bl_sync.sv
module smb_bl_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  // one extra stage holds the previous synchronised level
  localparam int unsigned DEPTH = STAGES + 1;

  logic [DEPTH-1:0] scl_sh, sda_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[DEPTH-2:0], scl_i};
      sda_sh <= {sda_sh[DEPTH-2:0], sda_i};
    end
  end

  logic scl_now, scl_prv, sda_now, sda_prv;
  assign scl_now = scl_sh[STAGES-1];
  assign scl_prv = scl_sh[STAGES];
  assign sda_now = sda_sh[STAGES-1];
  assign sda_prv = sda_sh[STAGES];

  assign sda_o      = sda_now;
  assign scl_rise_o = scl_now & ~scl_prv;
  assign scl_fall_o = ~scl_now & scl_prv;
  assign start_o    = scl_now & scl_prv & sda_prv & ~sda_now;
  assign stop_o     = scl_now & scl_prv & ~sda_prv & sda_now;

endmodule

// File: rtl/smb_bl_link.sv
module smb_bl_link
  import smb_bl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2C
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       sda_i,
  input  logic [7:0] rd_data_i,
  output logic [7:0] ptr_o,
  output logic       wr_en_o,
  output logic [7:0] wr_data_o,
  output logic       sda_oe_o
);

  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  link_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       sh_q, tx_q, ptr_q, wdat_q;
  logic             rw_q, ack_q, wr_q;

  logic shifting;
  assign shifting = (state_q == ST_ADDR) || (state_q == ST_CMD) || (state_q == ST_WR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      ptr_q   <= '0;
      wdat_q  <= '0;
      rw_q    <= 1'b0;
      ack_q   <= 1'b0;
      wr_q    <= 1'b0;
    end else begin
      wr_q <= 1'b0;
      if (start_i) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        ack_q   <= 1'b0;
      end else if (stop_i) begin
        state_q <= ST_IDLE;
        ack_q   <= 1'b0;
      end else if (shifting) begin
        if (scl_rise_i && cnt_q != CNT_FULL) begin
          sh_q  <= {sh_q[6:0], sda_i};
          cnt_q <= cnt_q + 1'b1;
        end else if (scl_fall_i && cnt_q == CNT_FULL) begin
          cnt_q <= '0;
          if (state_q == ST_ADDR) begin
            if (sh_q[7:1] == DEV_ADDR) begin
              rw_q    <= sh_q[0];
              ack_q   <= 1'b1;
              state_q <= ST_ADDR_ACK;
            end else begin
              state_q <= ST_SKIP;
            end
          end else if (state_q == ST_CMD) begin
            ptr_q   <= sh_q;
            ack_q   <= 1'b1;
            state_q <= ST_CMD_ACK;
          end else begin
            wdat_q  <= sh_q;
            wr_q    <= 1'b1;
            ack_q   <= 1'b1;
            state_q <= ST_WR_ACK;
          end
        end
      end else if (scl_fall_i) begin
        unique case (state_q)
          ST_ADDR_ACK: begin
            ack_q <= 1'b0;
            cnt_q <= '0;
            if (rw_q) begin
              tx_q    <= rd_data_i;
              state_q <= ST_RD;
            end else begin
              state_q <= ST_CMD;
            end
          end
          ST_CMD_ACK: begin
            ack_q   <= 1'b0;
            state_q <= ST_WR;
          end
          ST_WR_ACK: begin
            ack_q   <= 1'b0;
            state_q <= ST_SKIP;
          end
          ST_RD: begin
            if (cnt_q == CNT_LAST) begin
              state_q <= ST_RD_ACK;
            end else begin
              tx_q  <= {tx_q[6:0], 1'b0};
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_RD_ACK: state_q <= ST_SKIP;
          default: ;
        endcase
      end
    end
  end

  assign ptr_o     = ptr_q;
  assign wr_en_o   = wr_q;
  assign wr_data_o = wdat_q;
  assign sda_oe_o  = ack_q | ((state_q == ST_RD) & ~tx_q[7]);

endmodule

// File: rtl/smb_bl_regfile.sv
module smb_bl_regfile
  import smb_bl_pkg::*;
#(
  parameter int unsigned NUM_STRINGS = 8,
  parameter logic [3:0]  MAKER_ID    = 4'd6,
  parameter logic [2:0]  SILICON_REV = 3'd0
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [7:0]             ptr_i,
  input  logic [7:0]             wr_data_i,
  input  logic                   tsd_fault_i,
  input  logic                   ocp_fault_i,
  input  logic [NUM_STRINGS-1:0] string_fault_i,
  input  logic                   bl_status_i,
  output logic [7:0]             rd_data_o,
  output logic [7:0]             brt_o,
  output logic [2:0]             ctl_o
);

  localparam int unsigned CNT_W = $clog2(NUM_STRINGS + 1);

  logic [7:0] brt_q;
  logic [2:0] ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      brt_q <= 8'hFF;
      ctl_q <= 3'b000;
    end else if (wr_en_i) begin
      if (ptr_i == CMD_BRT) brt_q <= wr_data_i;
      if (ptr_i == CMD_CTL) ctl_q <= wr_data_i[2:0];
    end
  end

  logic [CNT_W-1:0] n_bad;
  always_comb begin
    n_bad = '0;
    for (int i = 0; i < NUM_STRINGS; i++) n_bad = n_bad + CNT_W'(string_fault_i[i]);
  end

  logic [1:0] cnt_code;
  always_comb begin
    if (n_bad == '0)                cnt_code = 2'b00;
    else if (n_bad == CNT_W'(1))    cnt_code = 2'b01;
    else                            cnt_code = 2'b11;
  end

  logic [7:0] sts;
  assign sts = {2'b00, cnt_code, bl_status_i, ocp_fault_i, tsd_fault_i,
                tsd_fault_i | ocp_fault_i | (|string_fault_i)};

  always_comb begin
    unique case (ptr_i)
      CMD_BRT: rd_data_o = brt_q;
      CMD_CTL: rd_data_o = {5'b00000, ctl_q};
      CMD_STS: rd_data_o = sts;
      CMD_ID:  rd_data_o = {1'b1, MAKER_ID, SILICON_REV};
      default: rd_data_o = 8'h00;
    endcase
  end

  assign brt_o = brt_q;
  assign ctl_o = ctl_q;

endmodule

// File: rtl/smb_bl_scale.sv
module smb_bl_scale (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] brt_i,
  input  logic [7:0] duty_i,
  input  logic       sel_pwm_i,
  input  logic       abs_i,
  output logic [7:0] eff_o
);

  logic [15:0] prod;
  assign prod = 16'(brt_i) * 16'(duty_i) + 16'd255;

  logic [7:0] eff_d, eff_q;
  always_comb begin
    if (sel_pwm_i)  eff_d = duty_i;
    else if (abs_i) eff_d = brt_i;
    else            eff_d = prod[15:8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) eff_q <= '0;
    else         eff_q <= eff_d;
  end

  assign eff_o = eff_q;

endmodule

// File: rtl/smb_backlight_regs.sv
module smb_backlight_regs
  import smb_bl_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h2C,
  parameter int unsigned NUM_STRINGS = 8,
  parameter logic [2:0]  SILICON_REV = 3'd0,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_oe_o,
  input  logic [7:0]             pwm_duty_i,
  input  logic                   tsd_fault_i,
  input  logic                   ocp_fault_i,
  input  logic [NUM_STRINGS-1:0] string_fault_i,
  input  logic                   bl_status_i,
  output logic [7:0]             brightness_o,
  output logic                   bl_en_o,
  output logic                   pwm_sel_o,
  output logic                   pwm_abs_o
);

  logic       sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic [7:0] ptr, wr_data, rd_data, brt_q;
  logic       wr_en;
  logic [2:0] ctl_q;

  smb_bl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_evt), .stop_o(stop_evt)
  );

  smb_bl_link #(.DEV_ADDR(DEV_ADDR)) u_link (
    .clk_i, .rst_ni,
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_evt), .stop_i(stop_evt), .sda_i(sda_s),
    .rd_data_i(rd_data), .ptr_o(ptr), .wr_en_o(wr_en),
    .wr_data_o(wr_data), .sda_oe_o
  );

  smb_bl_regfile #(
    .NUM_STRINGS(NUM_STRINGS), .SILICON_REV(SILICON_REV)
  ) u_regs (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .ptr_i(ptr), .wr_data_i(wr_data),
    .tsd_fault_i, .ocp_fault_i, .string_fault_i, .bl_status_i,
    .rd_data_o(rd_data), .brt_o(brt_q), .ctl_o(ctl_q)
  );

  smb_bl_scale u_scale (
    .clk_i, .rst_ni, .brt_i(brt_q), .duty_i(pwm_duty_i),
    .sel_pwm_i(ctl_q[CTL_SEL]), .abs_i(ctl_q[CTL_ABS]), .eff_o(brightness_o)
  );

  assign bl_en_o   = ctl_q[CTL_BL];
  assign pwm_sel_o = ctl_q[CTL_SEL];
  assign pwm_abs_o = ctl_q[CTL_ABS];

endmodule

// File: rtl/smb_bl_chk.sv
module smb_bl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [7:0] ptr_i,
  input logic [7:0] wr_data_i,
  input logic [7:0] brt_i,
  input logic       stop_i,
  input logic       sda_oe_i,
  input logic [7:0] duty_i,
  input logic [7:0] brightness_i,
  input logic       bl_en_i,
  input logic       sel_i,
  input logic       abs_i
);

  // R5
  ctl_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && ptr_i == 8'h01) |=> (bl_en_i == $past(wr_data_i[0]) &&
                                      sel_i == $past(wr_data_i[1]) &&
                                      abs_i == $past(wr_data_i[2])));

  // R8
  high_cmd_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && ptr_i >= 8'h04) |=> ($stable(brt_i) && $stable({bl_en_i, sel_i, abs_i})));

  // R10
  pwm_direct_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i |=> brightness_i == $past(duty_i));

  // R9
  smbus_abs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_i && abs_i) |=> brightness_i == $past(brt_i));

  // R11
  percent_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_i && !abs_i) |=> (brightness_i <= $past(brt_i) && brightness_i <= $past(duty_i)));

  // R12
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_i);

endmodule

bind smb_backlight_regs smb_bl_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en), .ptr_i(ptr),
  .wr_data_i(wr_data), .brt_i(brt_q), .stop_i(stop_evt), .sda_oe_i(sda_oe_o),
  .duty_i(pwm_duty_i), .brightness_i(brightness_o), .bl_en_i(bl_en_o),
  .sel_i(pwm_sel_o), .abs_i(pwm_abs_o)
);

// File: tb/smb_backlight_regs_tb_top.sv
module smb_backlight_regs_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int Q = 6;
  localparam int NS = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, m_sda = 1'b1;
  logic line_sda, sda_oe;
  logic [7:0] duty = 8'h80;
  logic tsd = 1'b0, ocp = 1'b0, bls = 1'b0;
  logic [NS-1:0] sfl = '0;
  logic [7:0] bright;
  logic bl_en, psel, pabs;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign line_sda = m_sda & ~sda_oe;

  smb_backlight_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(line_sda), .sda_oe_o(sda_oe),
    .pwm_duty_i(duty), .tsd_fault_i(tsd), .ocp_fault_i(ocp), .string_fault_i(sfl),
    .bl_status_i(bls), .brightness_o(bright), .bl_en_o(bl_en),
    .pwm_sel_o(psel), .pwm_abs_o(pabs)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] m_brt = 8'hFF;
  logic [2:0] m_ctl = 3'b000;
  logic [7:0] duty_seen = 8'h80;
  logic cmp_en = 1'b0;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model_eff(input logic [7:0] b, input logic [2:0] c,
                                           input logic [7:0] d);
    int p;
    if (c[1]) return d;
    if (c[2]) return b;
    p = (int'(b) * int'(d) + 255) / 256;
    return 8'(p);
  endfunction

  always @(posedge clk) duty_seen <= duty;

  always @(negedge clk) begin
    if (cmp_en) begin
      if (m_ctl[1])      check("R10 pwm direct", bright, model_eff(m_brt, m_ctl, duty_seen));
      else if (m_ctl[2]) check("R9 smbus abs", bright, model_eff(m_brt, m_ctl, duty_seen));
      else               check("R11 percent", bright, model_eff(m_brt, m_ctl, duty_seen));
      check("R5 ctl outputs", {5'd0, pabs, psel, bl_en}, {5'd0, m_ctl});
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic bus_rstart();
    m_sda = 1'b1; tick(Q);
    scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q);
    scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(Q);
      scl = 1'b1; tick(2*Q);
      scl = 1'b0; tick(Q);
    end
    m_sda = 1'b1; tick(Q);
    scl = 1'b1; tick(Q);
    ack = ~line_sda;
    tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b);
    b = '0;
    m_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(Q);
      scl = 1'b1; tick(Q);
      b = {b[6:0], line_sda};
      tick(Q);
      scl = 1'b0; tick(Q);
    end
    m_sda = 1'b1; tick(Q);
    scl = 1'b1; tick(Q);
    check("R3 sda released for master nack", {7'd0, line_sda}, 8'h01);
    tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic reg_write(input logic [7:0] ab, input logic [7:0] cmd, input logic [7:0] dat,
                           input string tag, input logic exp_ack);
    logic a0, a1, a2;
    cmp_en = 1'b0;
    bus_start();
    send_byte(ab, a0);
    send_byte(cmd, a1);
    send_byte(dat, a2);
    bus_stop();
    tick(4);
    check({tag, " ack bits"}, {5'd0, a0, a1, a2}, exp_ack ? 8'h07 : 8'h00);
    check("R12 sda released after stop", {7'd0, sda_oe}, 8'h00);
    if (exp_ack) begin
      if (cmd == 8'h00) m_brt = dat;
      if (cmd == 8'h01) m_ctl = dat[2:0];
    end
    cmp_en = 1'b1;
  endtask

  task automatic reg_read(input logic [7:0] ab, input logic [7:0] cmd, input logic [7:0] exp,
                          input string tag, input logic exp_ack);
    logic a0, a1, a2;
    logic [7:0] d;
    cmp_en = 1'b0;
    bus_start();
    send_byte(ab, a0);
    send_byte(cmd, a1);
    bus_rstart();
    send_byte(ab | 8'h01, a2);
    recv_byte(d);
    bus_stop();
    tick(4);
    check({tag, " ack bits"}, {5'd0, a0, a1, a2}, exp_ack ? 8'h07 : 8'h00);
    if (exp_ack) check(tag, d, exp);
    else         check({tag, " no drive"}, d, 8'hFF);
    check("R12 sda released after stop", {7'd0, sda_oe}, 8'h00);
    cmp_en = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(3);
    // reset state
    check("R4 reset brightness out", bright, 8'h80);
    check("R5 reset ctl outputs", {5'd0, pabs, psel, bl_en}, 8'h00);
    check("R12 reset sda idle", {7'd0, sda_oe}, 8'h00);
    cmp_en = 1'b1;

    reg_read(8'h58, 8'h00, 8'hFF, "R4 brightness reset read", 1'b1);
    reg_read(8'h58, 8'h01, 8'h00, "R5 ctl reset read", 1'b1);
    reg_read(8'h58, 8'h02, 8'h00, "R6 status idle", 1'b1);
    reg_read(8'h58, 8'h03, 8'hB0, "R7 id byte", 1'b1);

    // percent mode
    reg_write(8'h58, 8'h00, 8'h40, "R2 write brightness", 1'b1);
    check("R11 0x40 x 0x80", bright, 8'h20);
    duty = 8'hFF; tick(3);
    duty = 8'h00; tick(3);
    duty = 8'h01; tick(3);
    duty = 8'hA5; tick(1);
    duty = 8'h3C; tick(2);
    reg_write(8'h58, 8'h00, 8'hFF, "R2 write brightness max", 1'b1);
    duty = 8'hFF; tick(3);
    check("R11 full scale", bright, 8'hFF);
    duty = 8'h00; tick(3);
    check("R11 zero duty", bright, 8'h00);
    duty = 8'h77; tick(2);

    // absolute SMBus mode, upper ctl bits ignored
    reg_write(8'h58, 8'h01, 8'hFD, "R5 ctl write", 1'b1);
    reg_read(8'h58, 8'h01, 8'h05, "R5 ctl upper bits read zero", 1'b1);
    reg_write(8'h58, 8'h00, 8'h5A, "R9 brightness in abs mode", 1'b1);
    check("R9 abs output", bright, 8'h5A);
    duty = 8'h10; tick(3);

    // PWM direct mode
    reg_write(8'h58, 8'h01, 8'h03, "R10 select pwm", 1'b1);
    duty = 8'hC3; tick(3);
    reg_write(8'h58, 8'h00, 8'h11, "R10 brightness write in pwm mode", 1'b1);
    check("R10 output keeps duty", bright, 8'hC3);
    reg_read(8'h58, 8'h00, 8'h11, "R4 stored value read in pwm mode", 1'b1);
    reg_write(8'h58, 8'h01, 8'h00, "R5 backlight off", 1'b1);
    check("R5 bl_en cleared", {7'd0, bl_en}, 8'h00);

    // wrong address
    reg_write(8'h5A, 8'h00, 8'h99, "R1 foreign write", 1'b0);
    reg_read(8'h4A, 8'h00, 8'h00, "R1 foreign read", 1'b0);
    reg_read(8'h58, 8'h00, 8'h11, "R1 brightness untouched", 1'b1);

    // out of range command
    reg_write(8'h58, 8'h05, 8'h77, "R8 high cmd write", 1'b1);
    reg_read(8'h58, 8'h05, 8'h00, "R8 high cmd read", 1'b1);
    reg_read(8'h58, 8'h00, 8'h11, "R8 brightness untouched", 1'b1);
    reg_read(8'h58, 8'h01, 8'h00, "R8 ctl untouched", 1'b1);

    // status encoding
    tsd = 1'b1;
    reg_read(8'h58, 8'h02, 8'h03, "R6 thermal", 1'b1);
    tsd = 1'b0; bls = 1'b1; sfl = 8'b0001_0000;
    reg_read(8'h58, 8'h02, 8'h19, "R6 one string", 1'b1);
    bls = 1'b0; ocp = 1'b1; sfl = 8'b1000_0001;
    reg_read(8'h58, 8'h02, 8'h35, "R6 two strings", 1'b1);
    ocp = 1'b0; sfl = 8'hFF;
    reg_read(8'h58, 8'h02, 8'h31, "R6 all strings", 1'b1);
    sfl = '0;

    tick(10);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule